// File: doc/BRIEF.md
# Fractional Audio Master Clock Divider

This block produces an audio master clock from one of several input clock sources. Each source arrives as a single-cycle tick in the system clock domain. The block divides the selected tick stream by a ratio made of a 12-bit integer part and an 8-bit fraction. The output toggles once per interval. An interval lasts either the integer count of source ticks or one tick more. The choice comes from an 8-bit phase accumulator, so over many intervals the average spacing is the integer part plus the fraction divided by 256.

While the output is enabled, a new ratio can be loaded without stopping the clock. The loaded ratio waits in a holding register, and a busy flag is raised. The ratio takes over at the next output transition. Any further ratio write that arrives while the flag is up is discarded. When the output is disabled, the divider stops and its output is held low. The pin direction control then selects input, and the internal clock is taken straight from the pad. In this state a ratio write takes effect at once, and the busy flag stays low.

Top module: `mclk_frac_div`

## Requirements
- R1: With fraction 0 and integer part D ≥ 1, `mclk_out` toggles exactly every D ticks of the selected source. It changes only on a cycle where that source ticks.
- R2: With fraction F, each interval is D or D+1 ticks. The first interval after enable is D. After each transition the accumulator (cleared on enable) adds F modulo 256. A carry out of bit 7 makes the next interval D+1.
- R3: `upd_busy` is 0 after reset. It is 1 in the cycle after a ratio write is accepted while the output is enabled.
- R4: A ratio write made while `upd_busy` is 1 is ignored. The intervals keep following the previously accepted ratio.
- R5: A pending ratio sets the interval that begins at the next transition, and its fraction feeds that transition's accumulator step. `upd_busy` returns to 0 in the same cycle as that transition.
- R6: While `out_en` is 0, `mclk_oe` is 0 and `mclk_int` follows `pad_in`. While `out_en` is 1, `mclk_oe` is 1 and `mclk_int` equals `mclk_out`.
- R7: `mclk_out` is 0 during reset and in every cycle after one in which `out_en` was 0.
- R8: An integer part of 0 is treated as 1.
- R9: A ratio write while `out_en` is 0 loads directly, with `upd_busy` staying 0. The next enable uses the new ratio from its first interval.
- R10: `clk_sel` code 0 selects `src_tick[0]`, code 2 selects `src_tick[1]`, and code 3 selects `src_tick[2]`. Code 1 selects nothing, and the output never toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 3 | One-cycle ticks of the candidate input clocks |
| clk_sel | input | 2 | Source select code (0, 2, 3 valid; 1 = none) |
| div_val | input | 12 | Integer part of the ratio to write |
| frac_val | input | 8 | Fractional part of the ratio, in 1/256 |
| ratio_wr | input | 1 | Write strobe for `div_val`/`frac_val` |
| out_en | input | 1 | 1 = divider runs and drives the pin, 0 = bypass input |
| pad_in | input | 1 | Clock level seen on the pad when it is an input |
| mclk_out | output | 1 | Divided clock toggle output |
| mclk_oe | output | 1 | Pin output enable |
| mclk_int | output | 1 | Clock delivered to the rest of the chip |
| upd_busy | output | 1 | 1 while an on-the-fly ratio change is pending |

## Verification
Several properties are checked on every clock cycle. The output changes only on selected ticks and stays low whenever the block is idle. The interval counter stays below the interval length. The holding register does not move while the flag is up, and the flag never drops without an output transition. Only the bench scenarios can show the other behaviours: the exact spacing sequence for a given fraction, the point where a ratio change lands, the discarding of a second write, bypass routing, and the mapping of select codes to sources. To check these, the bench compares the measured tick count between transitions against a queue of expected intervals.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
    localparam int DIV_W  = 12;
    localparam int FRAC_W = 8;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 3;
    localparam int LEN_W  = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
    } ratio_t;

    typedef logic [LEN_W-1:0] len_t;

    // Integer part 0 behaves as 1
    function automatic len_t base_len(input logic [DIV_W-1:0] d);
        return (d == '0) ? len_t'(1) : len_t'(d);
    endfunction

    // Select code that routes source i: 0 -> 0, 1 -> 2, 2 -> 3
    function automatic logic [SEL_W-1:0] src_code(input int i);
        return (i == 0) ? SEL_W'(0) : SEL_W'(i + 1);
    endfunction
endpackage

// File: rtl/mdiv_src_mux.sv
module mdiv_src_mux
    import mdiv_pkg::*;
(
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = src_tick[i] && (sel == src_code(i));
    end

    assign tick = |hit;
endmodule

// File: rtl/mdiv_ratio_ctl.sv
module mdiv_ratio_ctl
    import mdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   wr,
    input  ratio_t wr_val,
    input  logic   edge_i,
    output ratio_t nxt,
    output logic   busy
);
    ratio_t cur_q, pend_q;
    logic   busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            pend_q <= '0;
            busy_q <= 1'b0;
        end else if (!en) begin
            busy_q <= 1'b0;
            if (wr) cur_q <= wr_val;
        end else begin
            if (edge_i && busy_q) begin
                cur_q  <= pend_q;
                busy_q <= 1'b0;
            end
            if (wr && !busy_q) begin
                pend_q <= wr_val;
                busy_q <= 1'b1;
            end
        end
    end

    assign nxt  = busy_q ? pend_q : cur_q;
    assign busy = busy_q;

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && en) |=> $stable(pend_q));
    // R5
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && en && !edge_i) |=> busy_q);
    // R9
    idle_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy_q);
endmodule

// File: rtl/mdiv_core.sv
module mdiv_core
    import mdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  ratio_t nxt,
    output logic   mclk,
    output logic   edge_o
);
    len_t              cnt_q, len_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum    = {1'b0, acc_q} + {1'b0, nxt.frac};
    assign edge_o = en && tick && ((cnt_q + len_t'(1)) == len_q);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            acc_q <= '0;
            len_q <= base_len(nxt.div);
            mclk  <= 1'b0;
        end else if (edge_o) begin
            mclk  <= ~mclk;
            cnt_q <= '0;
            acc_q <= sum[FRAC_W-1:0];
            len_q <= base_len(nxt.div) + len_t'(sum[FRAC_W]);
        end else if (tick) begin
            cnt_q <= cnt_q + len_t'(1);
        end
    end

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mclk);
    // R1
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(mclk));
    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < len_q));
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
    import mdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_tick,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic              ratio_wr,
    input  logic              out_en,
    input  logic              pad_in,
    output logic              mclk_out,
    output logic              mclk_oe,
    output logic              mclk_int,
    output logic              upd_busy
);
    logic   tick, edge_w;
    ratio_t wr_val, nxt;

    assign wr_val = '{div: div_val, frac: frac_val};

    mdiv_src_mux u_mux (
        .src_tick (src_tick),
        .sel      (clk_sel),
        .tick     (tick)
    );

    mdiv_ratio_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .en     (out_en),
        .wr     (ratio_wr),
        .wr_val (wr_val),
        .edge_i (edge_w),
        .nxt    (nxt),
        .busy   (upd_busy)
    );

    mdiv_core u_core (
        .clk    (clk),
        .rst    (rst),
        .en     (out_en),
        .tick   (tick),
        .nxt    (nxt),
        .mclk   (mclk_out),
        .edge_o (edge_w)
    );

    assign mclk_oe  = out_en;
    assign mclk_int = out_en ? mclk_out : pad_in;

    // R5
    busy_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_busy) && $past(out_en) |-> (mclk_out != $past(mclk_out)));
endmodule

// File: tb/mclk_frac_div_tb.sv
module mclk_frac_div_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_tick = '0;
    logic [1:0]  clk_sel = '0;
    logic [11:0] div_val = '0;
    logic [7:0]  frac_val = '0;
    logic        ratio_wr = 1'b0;
    logic        out_en = 1'b0;
    logic        pad_in = 1'b0;
    logic        mclk_out, mclk_oe, mclk_int, upd_busy;

    always #5 clk = ~clk;

    mclk_frac_div dut_i (
        .clk(clk), .rst(rst), .src_tick(src_tick), .clk_sel(clk_sel),
        .div_val(div_val), .frac_val(frac_val), .ratio_wr(ratio_wr),
        .out_en(out_en), .pad_in(pad_in), .mclk_out(mclk_out),
        .mclk_oe(mclk_oe), .mclk_int(mclk_int), .upd_busy(upd_busy)
    );

    int    q[$];
    int    total = 0, bad = 0;
    int    md = 0, mf = 0, macc = 0, mext = 0;
    string cur_req = "R1";
    int    ph = 0;
    int    cnt_t = 0;
    logic  tick_s = 1'b0, en_s = 1'b0, last_m = 1'b0;

    // source k ticks every k+1 cycles
    always @(negedge clk) begin
        ph <= ph + 1;
        for (int k = 0; k < 3; k++) src_tick[k] <= ((ph % (k + 1)) == 0);
    end

    function automatic int sel_idx(input logic [1:0] s);
        case (s)
            2'd0: return 0;
            2'd2: return 1;
            2'd3: return 2;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        int ix;
        ix = sel_idx(clk_sel);
        en_s   <= out_en && !rst;
        tick_s <= (ix >= 0) ? src_tick[ix] : 1'b0;
    end

    // monitor: measure ticks between output transitions, compare to queue
    always @(negedge clk) begin
        if (!en_s) begin
            cnt_t  = 0;
            last_m = mclk_out;
        end else begin
            if (tick_s) cnt_t++;
            if (mclk_out !== last_m) begin
                last_m = mclk_out;
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL %s unexpected edge: actual=%0d ticks expected=no edge", cur_req, cnt_t);
                end else begin
                    int e;
                    e = q.pop_front();
                    if (cnt_t != e) begin
                        bad++;
                        $display("FAIL %s interval: actual=%0d expected=%0d", cur_req, cnt_t, e);
                    end
                end
                cnt_t = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_len();
        return ((md == 0) ? 1 : md) + mext;
    endfunction

    task automatic advance();
        int s;
        s = macc + mf;
        mext = s / 256;
        macc = s % 256;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            q.push_back(model_len());
            advance();
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic drain();
        while (q.size() != 0) step(1);
    endtask

    task automatic write_ratio(input int d, input int f);
        div_val  = 12'(d);
        frac_val = 8'(f);
        ratio_wr = 1'b1;
        step(1);
        ratio_wr = 1'b0;
    endtask

    // disabled: select source, load ratio, enable and expect n intervals
    task automatic run_cfg(input string req, input logic [1:0] s, input int d, input int f, input int n);
        cur_req = req;
        out_en  = 1'b0;
        clk_sel = s;
        step(2);
        write_ratio(d, f);
        md = d; mf = f; macc = 0; mext = 0;
        step(2);
        push_n(n);
        out_en = 1'b1;
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        // R7 R3 reset state
        chk(mclk_out == 1'b0, "R7", int'(mclk_out), 0);
        chk(upd_busy == 1'b0, "R3", int'(upd_busy), 0);
        rst = 1'b0;
        step(2);

        // R1 integer divide
        run_cfg("R1", 2'd0, 4, 0, 6);
        // R2 fractional spacing
        run_cfg("R2", 2'd0, 2, 128, 10);
        run_cfg("R2", 2'd0, 1, 255, 10);
        run_cfg("R2", 2'd0, 3, 64, 9);
        // R8 zero integer part
        run_cfg("R8", 2'd0, 0, 0, 4);

        // R3 R4 R5 on-the-fly change
        run_cfg("R5", 2'd0, 5, 0, 3);
        begin
            int lk;
            lk = model_len();
            md = 3; mf = 100;
            advance();
            q.push_back(lk);
        end
        write_ratio(3, 100);
        chk(upd_busy == 1'b1, "R3", int'(upd_busy), 1);
        cur_req = "R4";
        write_ratio(9, 7);
        chk(upd_busy == 1'b1, "R4", int'(upd_busy), 1);
        drain();
        chk(upd_busy == 1'b0, "R5", int'(upd_busy), 0);
        push_n(7);
        drain();

        // R6 R7 bypass while disabled
        out_en = 1'b0;
        step(2);
        chk(mclk_out == 1'b0, "R7", int'(mclk_out), 0);
        chk(mclk_oe == 1'b0, "R6", int'(mclk_oe), 0);
        pad_in = 1'b1; #1;
        chk(mclk_int == 1'b1, "R6", int'(mclk_int), 1);
        pad_in = 1'b0; #1;
        chk(mclk_int == 1'b0, "R6", int'(mclk_int), 0);

        // R9 write while disabled loads directly
        cur_req = "R9";
        write_ratio(6, 0);
        md = 6; mf = 0; macc = 0; mext = 0;
        chk(upd_busy == 1'b0, "R9", int'(upd_busy), 0);
        step(2);
        push_n(4);
        out_en = 1'b1;
        step(1);
        chk(mclk_oe == 1'b1, "R6", int'(mclk_oe), 1);
        drain();
        chk(mclk_int == mclk_out, "R6", int'(mclk_int), int'(mclk_out));

        // R10 source mapping
        run_cfg("R10", 2'd2, 3, 0, 5);
        run_cfg("R10", 2'd3, 2, 128, 6);
        run_cfg("R10", 2'd1, 2, 0, 0);
        step(60);
        chk(mclk_out == 1'b0, "R10", int'(mclk_out), 0);
        out_en = 1'b0;
        step(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule